// File: doc/BRIEF.md
# Sub-word Addressable Data Register File

This block holds four 32-bit general data registers. Each can be reached as a whole word, as its low 16-bit half, or as either byte of that half. There is one write port and there are two read ports. Every port carries a register index and a two-bit part selector. A write to a narrow part merges into the stored word, so all bits outside the part keep their values. A read of a narrow part returns that part right-aligned, with the upper bits of the 32-bit result set to zero.

Register 0 serves as the accumulator. Register 3 extends it for double-width multiply and divide results. For that reason the pair is always visible as one 64-bit output, with register 3 in the upper word and register 0 in the lower word. Reads are combinational from the stored state. A write takes effect at the rising clock edge, so a read in the same cycle as a write sees the value held before that write.

Top module: `gpr_subword_file`

## Requirements
- R1: When the synchronous reset is sampled high, every register becomes zero at that clock edge.
- R2: With part selector 2'b00, a write replaces all 32 bits of the addressed register with wr_data.
- R3: With part selector 2'b01, a write loads wr_data[15:0] into bits 15:0 and leaves bits 31:16 unchanged.
- R4: With part selector 2'b10, a write loads wr_data[7:0] into bits 7:0 and leaves bits 31:8 unchanged.
- R5: With part selector 2'b11, a write loads wr_data[7:0] into bits 15:8 and leaves bits 31:16 and 7:0 unchanged.
- R6: A read returns a value chosen by its part selector: 2'b00 gives the whole word, 2'b01 gives bits 15:0, 2'b10 gives bits 7:0, and 2'b11 gives bits 15:8. Each narrow field sits at bit 0 of the read output, and all higher output bits are zero.
- R7: The two read ports work independently. Each has its own index and part selector, and they may address any register at the same time.
- R8: A read that addresses the register being written in the same cycle returns the value held before the write.
- R9: While wr_en is low, no register changes.
- R10: acc_pair always equals {register 3, register 0}.
- R11: A write changes only the register named by wr_idx. The other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 2 | Register index for the write |
| wr_part | input | 2 | Part selector for the write |
| wr_data | input | 32 | Write data; narrow parts take the low bits |
| rd0_idx | input | 2 | Register index for read port 0 |
| rd0_part | input | 2 | Part selector for read port 0 |
| rd0_data | output | 32 | Zero-extended read result of port 0 |
| rd1_idx | input | 2 | Register index for read port 1 |
| rd1_part | input | 2 | Part selector for read port 1 |
| rd1_data | output | 32 | Zero-extended read result of port 1 |
| acc_pair | output | 64 | Register 3 in bits 63:32, register 0 in bits 31:0 |

## Verification
The hardest case to reach is a narrow write that corrupts bits it should keep. It stays hidden unless the untouched bits differ from both the new data and zero. The sweep first preloads every register with a distinct non-trivial word. It then applies each part selector to each register with several data patterns. After every write it reads back all sixteen register-and-part combinations on both ports against a model. A write that aims both read ports at the target register in the write cycle exposes the read-before-write ordering.

// File: rtl/gprsw_pkg.sv
package gprsw_pkg;

  localparam int LANE_W = 8;
  localparam int HALF_W = 2 * LANE_W;
  localparam int REG_W  = 4 * LANE_W;

  typedef enum logic [1:0] {
    PART_W32 = 2'b00,
    PART_H16 = 2'b01,
    PART_BLO = 2'b10,
    PART_BHI = 2'b11
  } part_e;

  // Bits of the stored word that a write of part p may touch.
  function automatic logic [REG_W-1:0] part_mask(part_e p);
    logic [REG_W-1:0] m;
    case (p)
      PART_W32: m = {REG_W{1'b1}};
      PART_H16: m = {{(REG_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
      PART_BLO: m = {{(REG_W-LANE_W){1'b0}}, {LANE_W{1'b1}}};
      default:  m = {{(REG_W-HALF_W){1'b0}}, {LANE_W{1'b1}}, {LANE_W{1'b0}}};
    endcase
    return m;
  endfunction

  // Position right-aligned write data into the lanes of the chosen part.
  function automatic logic [REG_W-1:0] place_data(logic [REG_W-1:0] d, part_e p);
    return (p == PART_BHI) ? (d << LANE_W) : d;
  endfunction

  function automatic logic [REG_W-1:0] merge_part(logic [REG_W-1:0] old_v,
                                                  logic [REG_W-1:0] d,
                                                  part_e p);
    logic [REG_W-1:0] m;
    m = part_mask(p);
    return (old_v & ~m) | (place_data(d, p) & m);
  endfunction

  // Select a part and return it at bit 0, upper bits cleared.
  function automatic logic [REG_W-1:0] extract_part(logic [REG_W-1:0] v, part_e p);
    logic [REG_W-1:0] m;
    m = part_mask(p);
    return (p == PART_BHI) ? ((v & m) >> LANE_W) : (v & m);
  endfunction

endpackage

// File: rtl/gprsw_lane_merge.sv
module gprsw_lane_merge
  import gprsw_pkg::*;
(
  input  logic             hit,
  input  logic [REG_W-1:0] cur_q,
  input  logic [REG_W-1:0] wdata,
  input  logic [1:0]       wpart,
  output logic [REG_W-1:0] nxt
);
  always_comb begin
    nxt = hit ? merge_part(cur_q, wdata, part_e'(wpart)) : cur_q;
  end
endmodule

// File: rtl/gprsw_read_mux.sv
module gprsw_read_mux
  import gprsw_pkg::*;
#(
  parameter int NUM_REGS = 4,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][REG_W-1:0] regs,
  input  logic [IDX_W-1:0]               idx,
  input  logic [1:0]                     part,
  output logic [REG_W-1:0]               data
);
  always_comb begin
    data = extract_part(regs[idx], part_e'(part));
  end
endmodule

// File: rtl/gpr_subword_file.sv
module gpr_subword_file
  import gprsw_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int ACC_IDX  = 0,
  parameter int EXT_IDX  = 3,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [1:0]         wr_part,
  input  logic [REG_W-1:0]   wr_data,
  input  logic [IDX_W-1:0]   rd0_idx,
  input  logic [1:0]         rd0_part,
  output logic [REG_W-1:0]   rd0_data,
  input  logic [IDX_W-1:0]   rd1_idx,
  input  logic [1:0]         rd1_part,
  output logic [REG_W-1:0]   rd1_data,
  output logic [2*REG_W-1:0] acc_pair
);

  logic [NUM_REGS-1:0][REG_W-1:0] regs_q;
  logic [NUM_REGS-1:0][REG_W-1:0] regs_d;
  logic [NUM_REGS-1:0]            wr_hit;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    assign wr_hit[g] = wr_en && (wr_idx == IDX_W'(g));

    gprsw_lane_merge u_merge (
      .hit   (wr_hit[g]),
      .cur_q (regs_q[g]),
      .wdata (wr_data),
      .wpart (wr_part),
      .nxt   (regs_d[g])
    );

    always_ff @(posedge clk) begin
      if (rst) regs_q[g] <= '0;
      else     regs_q[g] <= regs_d[g];
    end
  end

  gprsw_read_mux #(.NUM_REGS(NUM_REGS)) u_rd0 (
    .regs (regs_q),
    .idx  (rd0_idx),
    .part (rd0_part),
    .data (rd0_data)
  );

  gprsw_read_mux #(.NUM_REGS(NUM_REGS)) u_rd1 (
    .regs (regs_q),
    .idx  (rd1_idx),
    .part (rd1_part),
    .data (rd1_data)
  );

  assign acc_pair = {regs_q[EXT_IDX], regs_q[ACC_IDX]};

endmodule

// File: rtl/gprsw_checker.sv
module gprsw_checker
  import gprsw_pkg::*;
#(
  parameter int NUM_REGS = 4,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [IDX_W-1:0]   wr_idx,
  input logic [1:0]         wr_part,
  input logic [REG_W-1:0]   wr_data,
  input logic [1:0]         rd0_part,
  input logic [IDX_W-1:0]   rd0_idx,
  input logic [REG_W-1:0]   rd0_data,
  input logic [2*REG_W-1:0] acc_pair,
  input logic [NUM_REGS-1:0] wr_hit
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> acc_pair == '0);

  a_r2_full_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == IDX_W'(3) && wr_part == PART_W32)
      |=> acc_pair[63:32] == $past(wr_data));

  a_r3_half_keeps_upper: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == IDX_W'(0) && wr_part == PART_H16)
      |=> acc_pair[31:16] == $past(acc_pair[31:16]) &&
          acc_pair[15:0] == $past(wr_data[15:0]));

  a_r4_low_byte: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == IDX_W'(0) && wr_part == PART_BLO)
      |=> acc_pair[31:8] == $past(acc_pair[31:8]) &&
          acc_pair[7:0] == $past(wr_data[7:0]));

  a_r5_high_byte: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == IDX_W'(3) && wr_part == PART_BHI)
      |=> acc_pair[63:48] == $past(acc_pair[63:48]) &&
          acc_pair[39:32] == $past(acc_pair[39:32]) &&
          acc_pair[47:40] == $past(wr_data[7:0]));

  a_r6_byte_zero_ext: assert property (@(posedge clk) disable iff (rst)
    (rd0_part == PART_BLO || rd0_part == PART_BHI) |-> rd0_data[31:8] == '0);

  a_r9_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(acc_pair));

  a_r10_pair_low: assert property (@(posedge clk) disable iff (rst)
    (rd0_idx == IDX_W'(0) && rd0_part == PART_W32) |-> rd0_data == acc_pair[31:0]);

  a_r11_single_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_hit) && (wr_en || wr_hit == '0));

  a_r11_other_untouched: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx != IDX_W'(0) && wr_idx != IDX_W'(3)) |=> $stable(acc_pair));

endmodule

bind gpr_subword_file gprsw_checker #(.NUM_REGS(NUM_REGS)) u_gprsw_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_idx   (wr_idx),
  .wr_part  (wr_part),
  .wr_data  (wr_data),
  .rd0_part (rd0_part),
  .rd0_idx  (rd0_idx),
  .rd0_data (rd0_data),
  .acc_pair (acc_pair),
  .wr_hit   (wr_hit)
);

// File: tb/tb_gpr_subword_file.sv
module tb_gpr_subword_file;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_idx = '0, wr_part = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd0_idx = '0, rd0_part = '0, rd1_idx = '0, rd1_part = '0;
  logic [31:0] rd0_data, rd1_data;
  logic [63:0] acc_pair;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] model [4];

  always #10 clk = ~clk;

  gpr_subword_file dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_part(wr_part),
    .wr_data(wr_data), .rd0_idx(rd0_idx), .rd0_part(rd0_part), .rd0_data(rd0_data),
    .rd1_idx(rd1_idx), .rd1_part(rd1_part), .rd1_data(rd1_data), .acc_pair(acc_pair)
  );

  function automatic logic [31:0] exp_read(logic [31:0] v, logic [1:0] p);
    case (p)
      2'd0: return v;
      2'd1: return v % 32'h10000;
      2'd2: return v % 32'h100;
      default: return (v / 32'h100) % 32'h100;
    endcase
  endfunction

  function automatic logic [31:0] exp_write(logic [31:0] o, logic [31:0] d, logic [1:0] p);
    case (p)
      2'd0: return d;
      2'd1: return (o - (o % 32'h10000)) + (d % 32'h10000);
      2'd2: return (o - (o % 32'h100)) + (d % 32'h100);
      default: return o - (((o / 32'h100) % 32'h100) * 32'h100) + ((d % 32'h100) * 32'h100);
    endcase
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All registers, all parts, on both ports (port 1 uses a rotated index).
  task automatic sweep_reads(string req);
    for (int r = 0; r < 4; r++) begin
      for (int p = 0; p < 4; p++) begin
        @(negedge clk);
        rd0_idx = 2'(r); rd0_part = 2'(p);
        rd1_idx = 2'(3 - r); rd1_part = 2'(3 - p);
        #2;
        check({req, "/R6 port0"}, {32'h0, rd0_data}, {32'h0, exp_read(model[r], 2'(p))});
        check({req, "/R7 port1"}, {32'h0, rd1_data}, {32'h0, exp_read(model[3 - r], 2'(3 - p))});
      end
    end
    check({req, "/R10 pair"}, acc_pair, {model[3], model[0]});
  endtask

  // Write with both read ports aimed at the target: they must show the old word.
  task automatic do_write(logic [1:0] idx, logic [1:0] part, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_part = part; wr_data = d;
    rd0_idx = idx; rd0_part = 2'd0; rd1_idx = idx; rd1_part = part;
    #2;
    check("R8 port0 old", {32'h0, rd0_data}, {32'h0, model[idx]});
    check("R8 port1 old", {32'h0, rd1_data}, {32'h0, exp_read(model[idx], part)});
    @(negedge clk);
    wr_en = 1'b0;
    model[idx] = exp_write(model[idx], d, part);
  endtask

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000;
    pats[2] = 32'hA5C3_5A3C; pats[3] = 32'h1234_8E71;
    for (int i = 0; i < 4; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    sweep_reads("R1 reset");

    for (int r = 0; r < 4; r++) do_write(2'(r), 2'd0, 32'h1357_9BDF + 32'(r) * 32'h1111_1111);
    sweep_reads("R2 preload");

    for (int r = 0; r < 4; r++)
      for (int p = 0; p < 4; p++)
        for (int k = 0; k < 4; k++) begin
          do_write(2'(r), 2'(p), pats[k] ^ (32'(r) << 4) ^ 32'(p));
          if (p == 1) sweep_reads("R3");
          else if (p == 2) sweep_reads("R4");
          else if (p == 3) sweep_reads("R5");
          else sweep_reads("R2 R11");
        end

    // R9: data presented with wr_en low must not land.
    @(negedge clk);
    wr_en = 1'b0; wr_idx = 2'd0; wr_part = 2'd0; wr_data = 32'hDEAD_BEEF;
    repeat (2) @(negedge clk);
    sweep_reads("R9 idle");

    // R1: reset after activity clears everything.
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 4; i++) model[i] = '0;
    sweep_reads("R1 rerun");

    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule